// File: doc/BRIEF.md
# Pixel-Rate Horizontal Clock and Sample Strobe Generator

This block produces the fast horizontal timing for an image-sensor readout. It runs on a master clock 48 times the pixel rate and keeps a position counter that walks through the 48 slots of one pixel period. From that counter it derives the reset-gate clock, a pair of complementary horizontal shift clocks, one-slot strobes that mark where the reset level and the data level are sampled, a pixel-rate data clock and a one-slot strobe for latching the data output.

Every edge location and drive code is held in a small register file loaded through a parallel write port (address, data, write enable). Writes land in a shadow copy and are made active only at the wrap from slot 47 to slot 0, so a waveform never changes shape partway through a period. The three clock outputs are each presented as a level, a 3-bit drive code for the analog driver, and an output enable that is low when the drive code is zero.

All outputs are registered. `pos_o` carries the slot that the other outputs describe in the same cycle.

Top module: `pxclk_edge_gen`

## Requirements
- R1: `pos_o` steps by one every clock from 0 to 47 and wraps from 47 back to 0; every other output describes the slot shown on `pos_o` in the same cycle.
- R2: `rg_o` is high for slots 0 up to one less than the active RG fall slot and low elsewhere; with a fall slot of 0 it stays low all period.
- R3: `h1_o` is high for the 24 slots starting at the active H1 rise slot and low for the other 24, wrapping past slot 47 (it falls at rise + 24 modulo 48).
- R4: `h2_o` is always the inverse of `h1_o`.
- R5: `shp_o` and `shd_o` are each high for exactly the one slot equal to their own active location field.
- R6: The drive codes for RG, H1 and H2 are 3 bits, appear on `rg_drv_o`, `h1_drv_o`, `h2_drv_o`, and the matching enable is low (three-state) exactly when the code is 0.
- R7: `dclk_o` is high for the 24 slots starting at the active data-clock phase slot and low for the remaining 24.
- R8: `dout_stb_o` is high for exactly the one slot equal to the active data-output phase field.
- R9: Write map: address 0 RG fall, 1 H1 rise, 2 SHP location, 3 SHD location, 4 data-clock phase, 5 data-output phase, each from `wr_data[5:0]`; address 6 holds the H1 drive code in `wr_data[2:0]` and the H2 drive code in `wr_data[5:3]`; address 7 holds the RG drive code in `wr_data[2:0]`.
- R10: A position value written as 48 to 63 behaves as that value minus 48.
- R11: A write made during a period leaves every output unchanged for the rest of that period; the new value first shows in the slot 0 that follows the next wrap.
- R12: While reset is held all fields are 0, `pos_o` reads 47, `h2_o` is 1 and every other output is 0; the first cycle after release shows slot 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock, 48 times the pixel rate |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Register address (see R9) |
| wr_data | input | 8 | Register write data |
| pos_o | output | 6 | Slot described by the other outputs this cycle |
| rg_o | output | 1 | Reset-gate level |
| rg_oe_o | output | 1 | Reset-gate enable, low means three-state |
| rg_drv_o | output | 3 | Reset-gate drive code |
| h1_o | output | 1 | Horizontal clock 1 level |
| h1_oe_o | output | 1 | Horizontal clock 1 enable |
| h1_drv_o | output | 3 | Horizontal clock 1 drive code |
| h2_o | output | 1 | Horizontal clock 2 level |
| h2_oe_o | output | 1 | Horizontal clock 2 enable |
| h2_drv_o | output | 3 | Horizontal clock 2 drive code |
| shp_o | output | 1 | Reset-level sample strobe |
| shd_o | output | 1 | Data-level sample strobe |
| dclk_o | output | 1 | Pixel-rate data clock |
| dout_stb_o | output | 1 | Data-output latch strobe |

## Verification
A wrong slot count shows at once on `pos_o` and within one period as a window that is shifted, stretched or missing on every waveform output. A bad shadow-to-active transfer shows as a waveform that changes shape mid-period or that keeps the old shape one period too long, which is visible within 48 cycles of a write. Wrong modulo reduction only shows for written values of 48 and up, so the sweeps cover every 6-bit code for each position field, and every drive code for each enable.

// File: rtl/pxg_pkg.sv
package pxg_pkg;

  localparam int PXG_POS_W = 6;
  localparam int PXG_DRV_W = 3;

  localparam logic [2:0] A_RG_FALL = 3'd0;
  localparam logic [2:0] A_H1_RISE = 3'd1;
  localparam logic [2:0] A_SHP     = 3'd2;
  localparam logic [2:0] A_SHD     = 3'd3;
  localparam logic [2:0] A_DCLK    = 3'd4;
  localparam logic [2:0] A_DOUT    = 3'd5;
  localparam logic [2:0] A_HDRV    = 3'd6;
  localparam logic [2:0] A_RGDRV   = 3'd7;

  typedef struct packed {
    logic [PXG_POS_W-1:0] rg_fall;
    logic [PXG_POS_W-1:0] h1_rise;
    logic [PXG_POS_W-1:0] shp_loc;
    logic [PXG_POS_W-1:0] shd_loc;
    logic [PXG_POS_W-1:0] dclk_ph;
    logic [PXG_POS_W-1:0] dout_ph;
    logic [PXG_DRV_W-1:0] h1_drv;
    logic [PXG_DRV_W-1:0] h2_drv;
    logic [PXG_DRV_W-1:0] rg_drv;
  } pxg_cfg_t;

endpackage

// File: rtl/pxg_counter.sv
module pxg_counter #(
  parameter int NPOS  = 48,
  parameter int POS_W = 6
) (
  input  logic             clk,
  input  logic             rst,
  output logic [POS_W-1:0] pos,
  output logic             wrap
);
  localparam logic [POS_W-1:0] LAST = POS_W'(NPOS - 1);
  localparam logic [POS_W-1:0] ONE  = POS_W'(1);

  assign wrap = (pos == LAST);

  always_ff @(posedge clk) begin
    if (rst)       pos <= '0;
    else if (wrap) pos <= '0;
    else           pos <= pos + ONE;
  end
endmodule

// File: rtl/pxg_regs.sv
module pxg_regs
  import pxg_pkg::*;
#(
  parameter int NPOS   = 48,
  parameter int POS_W  = PXG_POS_W,
  parameter int DRV_W  = PXG_DRV_W,
  parameter int ADDR_W = 3,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              wrap,
  output pxg_cfg_t          cfg_act
);
  localparam logic [POS_W-1:0] NPOS_L = POS_W'(NPOS);

  pxg_cfg_t        shadow;
  logic [POS_W-1:0] pos_in;

  // a 6-bit code is below twice the slot count, so one subtraction reduces it
  assign pos_in = (wr_data[POS_W-1:0] >= NPOS_L) ? wr_data[POS_W-1:0] - NPOS_L
                                                 : wr_data[POS_W-1:0];

  always_ff @(posedge clk) begin
    if (rst) begin
      shadow  <= '0;
      cfg_act <= '0;
    end else begin
      if (wr_en) begin
        case (wr_addr)
          A_RG_FALL: shadow.rg_fall <= pos_in;
          A_H1_RISE: shadow.h1_rise <= pos_in;
          A_SHP:     shadow.shp_loc <= pos_in;
          A_SHD:     shadow.shd_loc <= pos_in;
          A_DCLK:    shadow.dclk_ph <= pos_in;
          A_DOUT:    shadow.dout_ph <= pos_in;
          A_HDRV: begin
            shadow.h1_drv <= wr_data[DRV_W-1:0];
            shadow.h2_drv <= wr_data[2*DRV_W-1:DRV_W];
          end
          default:   shadow.rg_drv <= wr_data[DRV_W-1:0];
        endcase
      end
      if (wrap) cfg_act <= shadow;
    end
  end
endmodule

// File: rtl/pxg_wave.sv
module pxg_wave
  import pxg_pkg::*;
#(
  parameter int NPOS  = 48,
  parameter int POS_W = PXG_POS_W,
  parameter int DRV_W = PXG_DRV_W
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [POS_W-1:0] pos,
  input  pxg_cfg_t         cfg,
  output logic [POS_W-1:0] pos_o,
  output logic             rg_o,
  output logic             rg_oe_o,
  output logic [DRV_W-1:0] rg_drv_o,
  output logic             h1_o,
  output logic             h1_oe_o,
  output logic [DRV_W-1:0] h1_drv_o,
  output logic             h2_o,
  output logic             h2_oe_o,
  output logic [DRV_W-1:0] h2_drv_o,
  output logic             shp_o,
  output logic             shd_o,
  output logic             dclk_o,
  output logic             dout_stb_o
);
  localparam int NSTB = 3;
  localparam logic [POS_W:0]   NPOS_L = (POS_W+1)'(NPOS);
  localparam logic [POS_W:0]   HALF_L = (POS_W+1)'(NPOS / 2);
  localparam logic [POS_W-1:0] LAST   = POS_W'(NPOS - 1);

  function automatic logic in_half(input logic [POS_W-1:0] p, input logic [POS_W-1:0] s);
    logic [POS_W:0] d;
    if (p >= s) d = {1'b0, p} - {1'b0, s};
    else        d = {1'b0, p} + NPOS_L - {1'b0, s};
    return d < HALF_L;
  endfunction

  logic [POS_W-1:0] stb_loc [NSTB];
  logic [NSTB-1:0]  stb_hit;
  logic [NSTB-1:0]  stb_q;
  logic             h1_d;

  assign stb_loc[0] = cfg.shp_loc;
  assign stb_loc[1] = cfg.shd_loc;
  assign stb_loc[2] = cfg.dout_ph;

  for (genvar gi = 0; gi < NSTB; gi++) begin : g_stb
    assign stb_hit[gi] = (pos == stb_loc[gi]);
  end

  assign h1_d = in_half(pos, cfg.h1_rise);

  always_ff @(posedge clk) begin
    if (rst) begin
      pos_o    <= LAST;
      rg_o     <= 1'b0;
      h1_o     <= 1'b0;
      h2_o     <= 1'b1;
      dclk_o   <= 1'b0;
      stb_q    <= '0;
      rg_drv_o <= '0;
      h1_drv_o <= '0;
      h2_drv_o <= '0;
      rg_oe_o  <= 1'b0;
      h1_oe_o  <= 1'b0;
      h2_oe_o  <= 1'b0;
    end else begin
      pos_o    <= pos;
      rg_o     <= (pos < cfg.rg_fall);
      h1_o     <= h1_d;
      h2_o     <= ~h1_d;
      dclk_o   <= in_half(pos, cfg.dclk_ph);
      stb_q    <= stb_hit;
      rg_drv_o <= cfg.rg_drv;
      h1_drv_o <= cfg.h1_drv;
      h2_drv_o <= cfg.h2_drv;
      rg_oe_o  <= (cfg.rg_drv != '0);
      h1_oe_o  <= (cfg.h1_drv != '0);
      h2_oe_o  <= (cfg.h2_drv != '0);
    end
  end

  assign shp_o      = stb_q[0];
  assign shd_o      = stb_q[1];
  assign dout_stb_o = stb_q[2];
endmodule

// File: rtl/pxclk_edge_gen.sv
module pxclk_edge_gen
  import pxg_pkg::*;
#(
  parameter int NPOS   = 48,
  parameter int POS_W  = PXG_POS_W,
  parameter int DRV_W  = PXG_DRV_W,
  parameter int ADDR_W = 3,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  output logic [POS_W-1:0]  pos_o,
  output logic              rg_o,
  output logic              rg_oe_o,
  output logic [DRV_W-1:0]  rg_drv_o,
  output logic              h1_o,
  output logic              h1_oe_o,
  output logic [DRV_W-1:0]  h1_drv_o,
  output logic              h2_o,
  output logic              h2_oe_o,
  output logic [DRV_W-1:0]  h2_drv_o,
  output logic              shp_o,
  output logic              shd_o,
  output logic              dclk_o,
  output logic              dout_stb_o
);
  logic [POS_W-1:0] pos;
  logic             wrap;
  pxg_cfg_t         cfg_act;

  pxg_counter #(.NPOS(NPOS), .POS_W(POS_W)) u_cnt (
    .clk(clk), .rst(rst), .pos(pos), .wrap(wrap)
  );

  pxg_regs #(
    .NPOS(NPOS), .POS_W(POS_W), .DRV_W(DRV_W), .ADDR_W(ADDR_W), .DATA_W(DATA_W)
  ) u_regs (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .wrap(wrap), .cfg_act(cfg_act)
  );

  pxg_wave #(.NPOS(NPOS), .POS_W(POS_W), .DRV_W(DRV_W)) u_wave (
    .clk(clk), .rst(rst), .pos(pos), .cfg(cfg_act),
    .pos_o(pos_o),
    .rg_o(rg_o), .rg_oe_o(rg_oe_o), .rg_drv_o(rg_drv_o),
    .h1_o(h1_o), .h1_oe_o(h1_oe_o), .h1_drv_o(h1_drv_o),
    .h2_o(h2_o), .h2_oe_o(h2_oe_o), .h2_drv_o(h2_drv_o),
    .shp_o(shp_o), .shd_o(shd_o), .dclk_o(dclk_o), .dout_stb_o(dout_stb_o)
  );
endmodule

// File: rtl/pxg_checker.sv
module pxg_checker
  import pxg_pkg::*;
#(
  parameter int NPOS  = 48,
  parameter int POS_W = PXG_POS_W,
  parameter int DRV_W = PXG_DRV_W
) (
  input logic             clk,
  input logic             rst,
  input pxg_cfg_t         cfg,
  input logic [POS_W-1:0] pos_o,
  input logic             rg_o,
  input logic             rg_oe_o,
  input logic [DRV_W-1:0] rg_drv_o,
  input logic             h1_o,
  input logic             h1_oe_o,
  input logic [DRV_W-1:0] h1_drv_o,
  input logic             h2_o,
  input logic             h2_oe_o,
  input logic [DRV_W-1:0] h2_drv_o,
  input logic             shp_o,
  input logic             shd_o,
  input logic             dclk_o
);
  localparam logic [POS_W-1:0] LAST   = POS_W'(NPOS - 1);
  localparam logic [POS_W-1:0] ONE    = POS_W'(1);
  localparam logic [POS_W:0]   NPOS_L = (POS_W+1)'(NPOS);
  localparam logic [POS_W:0]   HALF_L = (POS_W+1)'(NPOS / 2);

  function automatic logic [POS_W-1:0] add_half(input logic [POS_W-1:0] s);
    logic [POS_W:0] t;
    t = {1'b0, s} + HALF_L;
    if (t >= NPOS_L) t = t - NPOS_L;
    return t[POS_W-1:0];
  endfunction

  // outputs in a cycle were built from the configuration active one cycle earlier
  logic [POS_W-1:0] h1_rise_q, h1_fall_q, dclk_rise_q, dclk_fall_q;
  always_ff @(posedge clk) begin
    h1_rise_q   <= cfg.h1_rise;
    h1_fall_q   <= add_half(cfg.h1_rise);
    dclk_rise_q <= cfg.dclk_ph;
    dclk_fall_q <= add_half(cfg.dclk_ph);
  end

  AST_POS_RANGE: assert property (@(posedge clk) disable iff (rst) pos_o <= LAST);              // R1
  AST_POS_STEP:  assert property (@(posedge clk) disable iff (rst)
                   (pos_o != LAST) |=> (pos_o == $past(pos_o) + ONE));                           // R1
  AST_POS_WRAP:  assert property (@(posedge clk) disable iff (rst) (pos_o == LAST) |=> (pos_o == '0)); // R1
  AST_RG_RISE:   assert property (@(posedge clk) disable iff (rst) $rose(rg_o) |-> (pos_o == '0)); // R2
  AST_H1_RISE:   assert property (@(posedge clk) disable iff (rst) (pos_o == h1_rise_q) |-> h1_o); // R3
  AST_H1_FALL:   assert property (@(posedge clk) disable iff (rst) (pos_o == h1_fall_q) |-> !h1_o); // R3
  AST_H2_INV:    assert property (@(posedge clk) disable iff (rst) h2_o != h1_o);                // R4
  AST_SHP_ONE:   assert property (@(posedge clk) disable iff (rst) shp_o |=> !shp_o);            // R5
  AST_SHD_ONE:   assert property (@(posedge clk) disable iff (rst) shd_o |=> !shd_o);            // R5
  AST_OE_OFF:    assert property (@(posedge clk) disable iff (rst)
                   ((h1_drv_o == '0) |-> !h1_oe_o) and ((h2_drv_o == '0) |-> !h2_oe_o)
                   and ((rg_drv_o == '0) |-> !rg_oe_o));                                          // R6
  AST_DCLK_RISE: assert property (@(posedge clk) disable iff (rst) (pos_o == dclk_rise_q) |-> dclk_o); // R7
  AST_DCLK_FALL: assert property (@(posedge clk) disable iff (rst) (pos_o == dclk_fall_q) |-> !dclk_o); // R7
  AST_CFG_HOLD:  assert property (@(posedge clk) disable iff (rst)
                   (pos_o != '0) |-> ($stable(h1_drv_o) && $stable(h2_drv_o) && $stable(rg_drv_o))); // R11
endmodule

bind pxclk_edge_gen pxg_checker #(.NPOS(NPOS), .POS_W(POS_W), .DRV_W(DRV_W)) u_chk (
  .clk(clk), .rst(rst), .cfg(cfg_act), .pos_o(pos_o),
  .rg_o(rg_o), .rg_oe_o(rg_oe_o), .rg_drv_o(rg_drv_o),
  .h1_o(h1_o), .h1_oe_o(h1_oe_o), .h1_drv_o(h1_drv_o),
  .h2_o(h2_o), .h2_oe_o(h2_oe_o), .h2_drv_o(h2_drv_o),
  .shp_o(shp_o), .shd_o(shd_o), .dclk_o(dclk_o)
);

// File: tb/pxclk_edge_gen_bench.sv
module pxclk_edge_gen_bench;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       wr_en = 1'b0;
  logic [2:0] wr_addr = '0;
  logic [7:0] wr_data = '0;
  logic [5:0] pos_o;
  logic       rg_o, rg_oe_o, h1_o, h1_oe_o, h2_o, h2_oe_o;
  logic [2:0] rg_drv_o, h1_drv_o, h2_drv_o;
  logic       shp_o, shd_o, dclk_o, dout_stb_o;

  int n_chk = 0;
  int n_bad = 0;
  bit done  = 1'b0;

  // bench model of the active configuration
  int m_rg = 0, m_h1 = 0, m_shp = 0, m_shd = 0, m_dclk = 0, m_dout = 0;
  int m_h1d = 0, m_h2d = 0, m_rgd = 0;

  always #4 clk = ~clk;

  pxclk_edge_gen u_pxclk_edge_gen (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .pos_o(pos_o), .rg_o(rg_o), .rg_oe_o(rg_oe_o), .rg_drv_o(rg_drv_o),
    .h1_o(h1_o), .h1_oe_o(h1_oe_o), .h1_drv_o(h1_drv_o),
    .h2_o(h2_o), .h2_oe_o(h2_oe_o), .h2_drv_o(h2_drv_o),
    .shp_o(shp_o), .shd_o(shd_o), .dclk_o(dclk_o), .dout_stb_o(dout_stb_o)
  );

  function automatic int red48(input int v);
    return (v >= 48) ? v - 48 : v;
  endfunction

  function automatic int win(input int p, input int s);
    return (((p - s + 48) % 48) < 24) ? 1 : 0;
  endfunction

  task automatic chk(input string req, input string what, input int got, input int exp);
    n_chk++;
    if (got != exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %0d expected %0d (pos_o=%0d)", req, what, got, exp, pos_o);
    end
  endtask

  task automatic wr(input int a, input int d);
    @(negedge clk);
    wr_en   = 1'b1;
    wr_addr = a[2:0];
    wr_data = d[7:0];
    @(negedge clk);
    wr_en   = 1'b0;
  endtask

  // wait at negedges until pos_o reads 0 twice, so all writes are active
  task automatic settle();
    int seen = 0;
    while (seen < 2) begin
      @(negedge clk);
      if (pos_o == 6'd0) seen++;
    end
  endtask

  task automatic check_slot(input int k);
    chk("R1",  "pos_o",      pos_o,      k);
    chk("R2",  "rg_o",       rg_o,       (k < m_rg) ? 1 : 0);
    chk("R3",  "h1_o",       h1_o,       win(k, m_h1));
    chk("R4",  "h2_o",       h2_o,       1 - win(k, m_h1));
    chk("R5",  "shp_o",      shp_o,      (k == m_shp) ? 1 : 0);
    chk("R5",  "shd_o",      shd_o,      (k == m_shd) ? 1 : 0);
    chk("R7",  "dclk_o",     dclk_o,     win(k, m_dclk));
    chk("R8",  "dout_stb_o", dout_stb_o, (k == m_dout) ? 1 : 0);
    chk("R6",  "h1_drv_o",   h1_drv_o,   m_h1d);
    chk("R6",  "h2_drv_o",   h2_drv_o,   m_h2d);
    chk("R6",  "rg_drv_o",   rg_drv_o,   m_rgd);
    chk("R6",  "h1_oe_o",    h1_oe_o,    (m_h1d != 0) ? 1 : 0);
    chk("R6",  "h2_oe_o",    h2_oe_o,    (m_h2d != 0) ? 1 : 0);
    chk("R6",  "rg_oe_o",    rg_oe_o,    (m_rgd != 0) ? 1 : 0);
  endtask

  // called at a negedge where pos_o is 0
  task automatic check_period();
    for (int k = 0; k < 48; k++) begin
      if (k > 0) @(negedge clk);
      check_slot(k);
    end
  endtask

  initial begin
    #(8 * 190000);
    if (!done) begin
      n_bad++;
      n_chk++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R12 reset state
    chk("R12", "pos_o reset",  pos_o, 47);
    chk("R12", "h2_o reset",   h2_o, 1);
    chk("R12", "h1_o reset",   h1_o, 0);
    chk("R12", "rg_o reset",   rg_o, 0);
    chk("R12", "oe reset",     {h1_oe_o, h2_oe_o, rg_oe_o}, 0);
    chk("R12", "strobe reset", {shp_o, shd_o, dclk_o, dout_stb_o}, 0);
    rst = 1'b0;
    @(negedge clk);
    chk("R12", "first slot after reset", pos_o, 0);
    check_period();

    // R2 R3 R5 R7 R8 R9 R10: sweep every 6-bit code through the position fields
    for (int i = 0; i < 64; i++) begin
      int v_h1, v_shp, v_shd, v_dc, v_do;
      v_h1  = (i * 7) % 64;
      v_shp = (i * 5 + 3) % 64;
      v_shd = (i * 11 + 1) % 64;
      v_dc  = (i * 13) % 64;
      v_do  = (i * 3 + 2) % 64;
      wr(0, i); wr(1, v_h1); wr(2, v_shp); wr(3, v_shd); wr(4, v_dc); wr(5, v_do);
      m_rg = red48(i); m_h1 = red48(v_h1); m_shp = red48(v_shp);
      m_shd = red48(v_shd); m_dclk = red48(v_dc); m_dout = red48(v_do);
      settle();
      check_period();
    end

    // R6 R9: every drive code; bits above the fields carry junk that must be ignored
    for (int d = 0; d < 8; d++) begin
      wr(6, 8'hC0 | ((7 - d) << 3) | d);
      wr(7, 8'hF8 | (d ^ 5));
      m_h1d = d; m_h2d = 7 - d; m_rgd = d ^ 5;
      settle();
      check_period();
    end

    // R11: a mid-period write must not disturb the current period
    wr(0, 40); m_rg = 40;
    settle();
    while (pos_o != 6'd10) @(negedge clk);
    wr_en = 1'b1; wr_addr = 3'd0; wr_data = 8'd5;
    @(negedge clk);
    wr_en = 1'b0;
    for (int k = 11; k < 48; k++) begin
      chk("R11", "rg_o before wrap", rg_o, (k < 40) ? 1 : 0);
      @(negedge clk);
    end
    m_rg = 5;
    check_period();

    // R2: fall slot 0 keeps the reset gate low; R3 with rise at 47 wraps
    wr(0, 48); wr(1, 47);
    m_rg = 0; m_h1 = 47;
    settle();
    check_period();

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule